// File: doc/BRIEF.md
# Debug-Clock-Qualified Reset Filter

This block sits behind one device pin that has two jobs: it is the active-low reset input, and it is also the bidirectional data line of a two-wire debug link. The filter watches the debug clock pin. While that clock is high, or while it keeps toggling, the block is in debug mode. In debug mode it holds the internal reset released, so low data bits on the shared pin cannot reset the device.

Once the debug clock has stayed low for a programmable number of system-clock samples, the block returns to pin mode. In pin mode, a low level on the shared pin resets the device again. Both pins are asynchronous to the system clock, so each is passed through a synchronizer before use. The internal reset output is registered in the system clock domain.

The timeout is a run-time input. Software or a fuse block can set how long a debug probe may pause its clock before the pin becomes a reset again.

Top module: `rstpin_dbg_filter`

## Requirements
- R1: While `rst_n` is sampled low at a rising `clk` edge, the block goes to pin mode. After that edge, `dbg_mode_o` is 0 and `sys_rst_n_o` is 0 (reset asserted).
- R2: A high level on `dbg_clk_i` that has passed the synchronizer moves the block into debug mode. The latency is fixed: if `dbg_clk_i` rises between edges, `dbg_mode_o` reads 1 after the third rising `clk` edge.
- R3: In debug mode, and in any cycle in which the synchronized debug clock is high, `sys_rst_n_o` is held at 1 whatever the level of `pin_i`.
- R4: Debug mode ends after `timeout_i` consecutive synchronized low samples of the debug clock. A `timeout_i` of 0 acts as 1. If `dbg_clk_i` falls between edges, `dbg_mode_o` reads 1 after edge T+1 and reads 0 after edge T+2, where T is the effective timeout.
- R5: A low period of the debug clock shorter than T synchronized samples, followed by a high level, leaves debug mode in place. The low-sample count restarts at zero on every synchronized high level.
- R6: In pin mode, with the synchronized debug clock low, `sys_rst_n_o` follows the level of `pin_i` (low means reset) three rising `clk` edges after the pin changes. This covers two synchronizer stages plus the output register.
- R7: After debug mode times out, a new high level on the debug clock enters debug mode again, with the same latency as R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low power-on reset |
| dbg_clk_i | input | 1 | Raw debug clock pin, asynchronous |
| pin_i | input | 1 | Raw shared reset/debug-data pin, asynchronous, low = reset request |
| timeout_i | input | TMO_W | Number of synchronized low debug-clock samples that ends debug mode (0 treated as 1) |
| sys_rst_n_o | output | 1 | Filtered internal reset, active low, registered |
| dbg_mode_o | output | 1 | 1 while the pin is owned by the debug link |

## Verification
A mode register that is stuck or that leaves too early shows up at `sys_rst_n_o`. It goes low one edge after `dbg_mode_o` drops while the pin is low, which is T+3 edges after the debug clock stops. Releasing one edge early or late moves that transition, so the bench sweeps the timeout and checks the exact edge.

A low-sample counter that does not restart on a high level also shows up at the ports. With back-to-back pulses just shorter than the timeout, such a counter drops debug mode and pulls reset low, and the bench sees this within a few edges.

A wrong synchronizer depth or missing output register moves the pin-to-reset latency away from three edges.

// File: rtl/rstpin_dbg_pkg.sv
// Shared types and defaults for the debug-clock-qualified reset filter.
package rstpin_dbg_pkg;

    // Ownership of the shared pin.
    typedef enum logic {
        OWN_PIN = 1'b0,   // pin acts as active-low reset
        OWN_DBG = 1'b1    // pin carries debug data; reset suppressed
    } pin_owner_e;

    localparam int DEF_TMO_W       = 8;
    localparam int DEF_SYNC_STAGES = 2;

endpackage

// File: rtl/rstpin_sync.sv
// Multi-stage level synchronizer for one asynchronous bit.
// Assumes: input is a slow level relative to clk; RST_VAL is the safe level.
module rstpin_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain_q;

    // Shift the raw bit through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= {STAGES{RST_VAL}};
        else        chain_q <= {chain_q[STAGES-2:0], d_i};
    end

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/rstpin_dbg_watch.sv
// Tracks debug-clock activity and decides who owns the shared pin.
// Assumes: dbg_s_i is already synchronized to clk.
// Enters OWN_DBG on any high sample. Returns to OWN_PIN after tmo_i
// consecutive low samples (0 treated as 1).
module rstpin_dbg_watch
    import rstpin_dbg_pkg::*;
#(
    parameter int TMO_W = DEF_TMO_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             dbg_s_i,
    input  logic [TMO_W-1:0] tmo_i,
    output pin_owner_e       owner_o
);
    localparam int CW = TMO_W + 1;

    pin_owner_e       owner_q;
    logic [TMO_W-1:0] low_cnt_q;
    logic [CW-1:0]    tmo_eff;
    logic [CW-1:0]    low_next;
    logic             expire;

    // Effective limit and next low-sample count.
    always_comb begin
        tmo_eff  = (tmo_i == '0) ? CW'(1) : {1'b0, tmo_i};
        low_next = {1'b0, low_cnt_q} + CW'(1);
        expire   = (owner_q == OWN_DBG) && !dbg_s_i && (low_next >= tmo_eff);
    end

    // Ownership state machine.
    always_ff @(posedge clk) begin
        if (!rst_n)                         owner_q <= OWN_PIN;
        else if (dbg_s_i)                   owner_q <= OWN_DBG;
        else if (expire)                    owner_q <= OWN_PIN;
    end

    // Consecutive-low counter; restarts on high level or outside debug mode.
    always_ff @(posedge clk) begin
        if (!rst_n)                                   low_cnt_q <= '0;
        else if (dbg_s_i || owner_q == OWN_PIN || expire) low_cnt_q <= '0;
        else                                          low_cnt_q <= low_next[TMO_W-1:0];
    end

    assign owner_o = owner_q;
endmodule

// File: rtl/rstpin_rst_gate.sv
// Produces the registered internal reset from the synchronized pin.
// Assumes: inputs synchronous to clk. Reset is forced released while
// the debug link owns the pin or the synchronized debug clock is high.
module rstpin_rst_gate
    import rstpin_dbg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pin_s_i,
    input  logic       dbg_s_i,
    input  pin_owner_e owner_i,
    output logic       sys_rst_n_o
);
    logic suppress;

    // Suppress when debug owns the pin or its clock is currently high.
    always_comb suppress = (owner_i == OWN_DBG) || dbg_s_i;

    // Register the filtered reset; asserted during power-on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)        sys_rst_n_o <= 1'b0;
        else if (suppress) sys_rst_n_o <= 1'b1;
        else               sys_rst_n_o <= pin_s_i;
    end
endmodule

// File: rtl/rstpin_dbg_filter.sv
// Top of the debug-clock-qualified reset filter.
// Assumes: both pins asynchronous to clk; timeout_i quasi-static.
module rstpin_dbg_filter
    import rstpin_dbg_pkg::*;
#(
    parameter int TMO_W       = DEF_TMO_W,
    parameter int SYNC_STAGES = DEF_SYNC_STAGES
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             dbg_clk_i,
    input  logic             pin_i,
    input  logic [TMO_W-1:0] timeout_i,
    output logic             sys_rst_n_o,
    output logic             dbg_mode_o
);
    logic       dbg_s;
    logic       pin_s;
    pin_owner_e owner;

    rstpin_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_dbg (
        .clk(clk), .rst_n(rst_n), .d_i(dbg_clk_i), .q_o(dbg_s)
    );

    rstpin_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_pin (
        .clk(clk), .rst_n(rst_n), .d_i(pin_i), .q_o(pin_s)
    );

    rstpin_dbg_watch #(.TMO_W(TMO_W)) u_watch (
        .clk(clk), .rst_n(rst_n), .dbg_s_i(dbg_s),
        .tmo_i(timeout_i), .owner_o(owner)
    );

    rstpin_rst_gate u_gate (
        .clk(clk), .rst_n(rst_n), .pin_s_i(pin_s), .dbg_s_i(dbg_s),
        .owner_i(owner), .sys_rst_n_o(sys_rst_n_o)
    );

    // Expose ownership as a plain flag.
    always_comb dbg_mode_o = (owner == OWN_DBG);
endmodule

// File: rtl/rstpin_dbg_filter_chk.sv
// Property checker for rstpin_dbg_filter, attached by bind.
module rstpin_dbg_filter_chk (
    input logic clk,
    input logic rst_n,
    input logic dbg_s,
    input logic pin_s,
    input logic mode,
    input logic rst_o
);
    AST_ENTER_ON_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        dbg_s |=> mode);                                             // R2
    AST_SUPPRESS_IN_DBG: assert property (@(posedge clk) disable iff (!rst_n)
        mode |=> rst_o);                                             // R3
    AST_EXIT_ONLY_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (mode && dbg_s) |=> mode);                                   // R5
    AST_PIN_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode && !dbg_s) |=> (rst_o == $past(pin_s)));              // R6
endmodule

bind rstpin_dbg_filter rstpin_dbg_filter_chk u_chk (
    .clk(clk), .rst_n(rst_n), .dbg_s(dbg_s), .pin_s(pin_s),
    .mode(dbg_mode_o), .rst_o(sys_rst_n_o)
);

// File: tb/rstpin_dbg_filter_tb.sv
// Sweep bench: timeouts 0..6, pulse lengths below each timeout.
module rstpin_dbg_filter_tb;
    localparam int TMO_W = 8;

    logic             clk = 1'b0;
    logic             rst_n;
    logic             dbg_clk_i;
    logic             pin_i;
    logic [TMO_W-1:0] timeout_i;
    logic             sys_rst_n_o;
    logic             dbg_mode_o;

    int n_cmp = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    rstpin_dbg_filter #(.TMO_W(TMO_W), .SYNC_STAGES(2)) u_dut (
        .clk(clk), .rst_n(rst_n), .dbg_clk_i(dbg_clk_i), .pin_i(pin_i),
        .timeout_i(timeout_i), .sys_rst_n_o(sys_rst_n_o), .dbg_mode_o(dbg_mode_o)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic act, input logic exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    initial begin
        #2_000_000;
        n_bad++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0; dbg_clk_i = 1'b0; pin_i = 1'b1; timeout_i = 8'd4;
        tick(4);
        chk("R1 rst", sys_rst_n_o, 1'b0);
        chk("R1 mode", dbg_mode_o, 1'b0);
        rst_n = 1'b1;
        tick(3);
        chk("R6 release", sys_rst_n_o, 1'b1);

        // Pin-mode latency.
        pin_i = 1'b0;
        tick(2); chk("R6 lat-2", sys_rst_n_o, 1'b1);
        tick(1); chk("R6 lat-3", sys_rst_n_o, 1'b0);
        pin_i = 1'b1;
        tick(2); chk("R6 rel-2", sys_rst_n_o, 1'b0);
        tick(1); chk("R6 rel-3", sys_rst_n_o, 1'b1);

        for (int t = 0; t <= 6; t++) begin
            automatic int te = (t == 0) ? 1 : t;
            timeout_i = TMO_W'(t);
            // Entry: pin drops at the same moment as debug clock rises.
            dbg_clk_i = 1'b1; pin_i = 1'b0;
            tick(2); chk("R2 pre", dbg_mode_o, 1'b0);
            tick(1); chk("R2 enter", dbg_mode_o, 1'b1);
            chk("R3 same-edge", sys_rst_n_o, 1'b1);
            tick(20);
            chk("R3 held-high", sys_rst_n_o, 1'b1);
            chk("R3 mode", dbg_mode_o, 1'b1);
            // Low pulses shorter than the timeout.
            for (int l = 1; l < te; l++) begin
                dbg_clk_i = 1'b0; tick(l);
                dbg_clk_i = 1'b1; tick(3);
                chk("R5 mode", dbg_mode_o, 1'b1);
                chk("R5 rst", sys_rst_n_o, 1'b1);
            end
            // Back-to-back pulses of te-1 must not accumulate.
            if (te > 1) begin
                for (int k = 0; k < 3; k++) begin
                    dbg_clk_i = 1'b0; tick(te - 1);
                    dbg_clk_i = 1'b1; tick(1);
                end
                tick(2);
                chk("R5 restart", dbg_mode_o, 1'b1);
            end
            // Timeout.
            dbg_clk_i = 1'b0;
            tick(te + 1); chk("R4 before", dbg_mode_o, 1'b1);
            chk("R3 pin-low", sys_rst_n_o, 1'b1);
            tick(1);      chk("R4 exit", dbg_mode_o, 1'b0);
            chk("R4 rst-hold", sys_rst_n_o, 1'b1);
            tick(1);      chk("R6 after-exit", sys_rst_n_o, 1'b0);
            pin_i = 1'b1;
            tick(3);      chk("R6 high", sys_rst_n_o, 1'b1);
            // Re-entry.
            dbg_clk_i = 1'b1;
            tick(2); chk("R7 pre", dbg_mode_o, 1'b0);
            tick(1); chk("R7 reenter", dbg_mode_o, 1'b1);
            dbg_clk_i = 1'b0;
            tick(te + 3);
            chk("R7 leave", dbg_mode_o, 1'b0);
        end

        // Reset during debug mode.
        dbg_clk_i = 1'b1; tick(4);
        rst_n = 1'b0; dbg_clk_i = 1'b0; tick(1);
        chk("R1 mid mode", dbg_mode_o, 1'b0);
        chk("R1 mid rst", sys_rst_n_o, 1'b0);
        rst_n = 1'b1; tick(3);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule